// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block serialises one byte at a time into an asynchronous frame whose shape is chosen by a six-bit format input. The host writes a byte into a one-entry holding register. When the shift engine is idle it takes the byte and the current format in the same clock edge, and then sends the frame on the serial line. Each bit lasts a fixed number of enables of an oversampling tick, 16 by default.

The format input selects four things:

- the data word length, from 5 to 8 bits;
- whether a parity bit is sent;
- which of four parity rules applies: odd, even, forced one or forced zero;
- a normal or long stop period.

With a 5-bit word, the long stop period is one and a half bit times. With any longer word, it is two bit times.

Two flags tell the host what it may do next. The first flag shows that the holding register can take a new byte. The second flag shows that both the holding register and the shift engine are empty, so the line has gone quiet.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_out` is 1 and both `hold_empty` and `line_idle` are 1; whenever no frame is being sent, `tx_out` is 1.
- R2: `line_ctl[1:0]` selects the data word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits are not sent.
- R3: When `line_ctl[3]` is 0, no parity bit is sent, whatever the values of `line_ctl[5:4]`.
- R4: When `line_ctl[3]` is 1, a parity bit follows the data bits. `line_ctl[5:4]` selects its value:
  - 00: odd parity, so the data bits plus the parity bit hold an odd count of ones;
  - 01: even parity;
  - 10: the parity bit is always 1;
  - 11: the parity bit is always 0.
- R5: When `line_ctl[2]` is 0, the stop period is one bit time (16 ticks) at 1 for every word length.
- R6: When `line_ctl[2]` is 1, the stop period is 24 ticks for a 5-bit word and 32 ticks for a 6-, 7- or 8-bit word.
- R7: `hold_empty` falls at the clock edge that captures a write. It rises at the edge where the byte moves into the shift engine, unless a write lands on that same edge.
- R8: `line_idle` is 1 only when the holding register is empty and no frame is in progress. It rises at the clock edge after the last tick of the stop period.
- R9: A frame is a start bit at 0, then the data bits LSB first, then the parity bit if enabled, then the stop period. Every bit except the stop period lasts exactly 16 tick enables. The start bit appears at the load edge.
- R10: The format is captured when the byte is loaded into the shift engine. Changing `line_ctl` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| line_ctl | input | 6 | Frame format: [1:0] word length, [2] long stop, [3] parity on, [5:4] parity rule |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_out | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can accept a byte |
| line_idle | output | 1 | Holding register and shift engine both empty |

## Verification
A write is captured at edge E1, so `hold_empty` is low from E1. If the line is idle, the byte loads at E1+1: `hold_empty` rises again, `line_idle` stays low and the start bit is driven from that edge onward. Bit n of the frame is on the line before tick edges 16n through 16n+15 after the load. `line_idle` rises at the first edge after the final stop tick, and a byte already waiting loads one edge later. The bench samples every output on the falling clock edge. Before each tick edge it compares the line against the bit index, which it computes from the tick count since the load. It sweeps all 64 format codes with two data patterns each, plus a back-to-back pair with the format changed mid-frame.

// File: rtl/uft_pkg.sv
package uft_pkg;

   typedef enum logic [1:0] {
      PAR_ODD  = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ONE  = 2'b10,
      PAR_ZERO = 2'b11
   } par_rule_e;

   // bit layout matches the line_ctl port: [5:4] rule, [3] on, [2] long stop, [1:0] length
   typedef struct packed {
      par_rule_e  rule;
      logic       par_on;
      logic       long_stop;
      logic [1:0] wlen;
   } fmt_t;

endpackage

// File: rtl/uft_hold.sv
module uft_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_full
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (wr_en) begin
         hold_full <= 1'b1;
         hold_data <= wr_data;
      end else if (take) begin
         hold_full <= 1'b0;
      end
   end

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> hold_full); // R7

endmodule

// File: rtl/uft_framer.sv
module uft_framer
   import uft_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16,
   parameter int FRAME_W    = DATA_W + 2,
   parameter int CNT_W      = 8
) (
   input  fmt_t               fmt,
   input  logic [DATA_W-1:0]  data,
   output logic [FRAME_W-1:0] frame_bits,
   output logic [CNT_W-1:0]   total_ticks
);

   localparam int HALF_BIT = OVERSAMPLE / 2;

   int                nd;
   logic [DATA_W-1:0] masked;
   logic              par_bit;
   int                stop_ticks;
   int                tot;

   assign nd = DATA_W - 3 + int'(fmt.wlen);

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign masked[g] = data[g] & (g < nd);
   end

   always_comb begin
      unique case (fmt.rule)
         PAR_ODD:  par_bit = ~^masked;
         PAR_EVEN: par_bit = ^masked;
         PAR_ONE:  par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
   end

   always_comb begin
      frame_bits    = '1;
      frame_bits[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < nd) frame_bits[1+i] = data[i];
      end
      if (fmt.par_on) frame_bits[1+nd] = par_bit;
   end

   always_comb begin
      if (!fmt.long_stop)     stop_ticks = OVERSAMPLE;
      else if (fmt.wlen == 0) stop_ticks = OVERSAMPLE + HALF_BIT;
      else                    stop_ticks = 2 * OVERSAMPLE;
      tot         = OVERSAMPLE * (1 + nd + int'(fmt.par_on)) + stop_ticks;
      total_ticks = CNT_W'(tot);
   end

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter #(
   parameter int FRAME_W    = 10,
   parameter int OVERSAMPLE = 16,
   parameter int CNT_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_bits,
   input  logic [CNT_W-1:0]   total_ticks,
   output logic               busy,
   output logic               tx
);

   localparam int SUB_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   remaining;
   logic [SUB_W-1:0]   sub;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh        <= '1;
         remaining <= '0;
         sub       <= '0;
         busy      <= 1'b0;
      end else if (load) begin
         sh        <= frame_bits;
         remaining <= total_ticks;
         sub       <= '0;
         busy      <= 1'b1;
      end else if (busy && tick) begin
         remaining <= remaining - 1'b1;
         if (remaining == 1) busy <= 1'b0;
         if (sub == SUB_LAST) begin
            sub <= '0;
            sh  <= {1'b1, sh[FRAME_W-1:1]};
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   assign tx = busy ? sh[0] : 1'b1;

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !tx); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (remaining != 0)); // R9
   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !load) |=> ($stable(tx) && busy)); // R9

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uft_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [5:0]        line_ctl,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_out,
   output logic              hold_empty,
   output logic              line_idle
);

   localparam int FRAME_W = DATA_W + 2;
   localparam int MAX_TKS = OVERSAMPLE * (FRAME_W + 2);
   localparam int CNT_W   = $clog2(MAX_TKS + 1);

   if (DATA_W < 4 || DATA_W > 16) begin : g_bad_width
      $error("uart_frame_tx: DATA_W must lie in 4..16");
   end
   if (OVERSAMPLE < 2 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("uart_frame_tx: OVERSAMPLE must be even and at least 2");
   end

   logic [DATA_W-1:0]  hold_data;
   logic               hold_full;
   logic               busy;
   logic               load;
   logic [FRAME_W-1:0] frame_bits;
   logic [CNT_W-1:0]   total_ticks;

   assign load = hold_full && !busy;

   uft_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .take      (load),
      .hold_data (hold_data),
      .hold_full (hold_full)
   );

   uft_framer #(
      .DATA_W     (DATA_W),
      .OVERSAMPLE (OVERSAMPLE),
      .FRAME_W    (FRAME_W),
      .CNT_W      (CNT_W)
   ) u_framer (
      .fmt         (fmt_t'(line_ctl)),
      .data        (hold_data),
      .frame_bits  (frame_bits),
      .total_ticks (total_ticks)
   );

   uft_shifter #(
      .FRAME_W    (FRAME_W),
      .OVERSAMPLE (OVERSAMPLE),
      .CNT_W      (CNT_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .load        (load),
      .frame_bits  (frame_bits),
      .total_ticks (total_ticks),
      .busy        (busy),
      .tx          (tx_out)
   );

   assign hold_empty = !hold_full;
   assign line_idle  = !hold_full && !busy;

   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      line_idle |-> tx_out); // R1
   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !hold_empty); // R7
   AST_LOAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_en) |=> (hold_empty && !line_idle)); // R8

endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tcnt = 1'b0;
   logic       tick;
   logic [5:0] line_ctl = 6'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       tx_out, hold_empty, line_idle;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;
   always @(posedge clk) tcnt <= ~tcnt;
   assign tick = tcnt;

   uart_frame_tx uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_ctl(line_ctl),
      .wr_en(wr_en), .wr_data(wr_data), .tx_out(tx_out),
      .hold_empty(hold_empty), .line_idle(line_idle)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic frame_bit(input logic [5:0] f, input logic [7:0] d, input int j);
      int nd;
      logic [7:0] m;
      logic par;
      nd = 5 + int'(f[1:0]);
      m  = d & 8'((1 << nd) - 1);
      case (f[5:4])
         2'b00:   par = ~^m;
         2'b01:   par = ^m;
         2'b10:   par = 1'b1;
         default: par = 1'b0;
      endcase
      if (j == 0) return 1'b0;
      if (j <= nd) return d[j-1];
      if (j == nd + 1 && f[3]) return par;
      return 1'b1;
   endfunction

   function automatic int frame_ticks(input logic [5:0] f);
      int nd, stp;
      nd  = 5 + int'(f[1:0]);
      stp = !f[2] ? 16 : (nd == 5 ? 24 : 32);
      return 16 * (1 + nd + int'(f[3])) + stp;
   endfunction

   // Runs from the negedge just after the load edge to the negedge after the last tick edge.
   task automatic check_frame(input logic [5:0] f, input logic [7:0] d,
                              input bit mid_wr, input logic [5:0] f2, input logic [7:0] d2);
      int total = frame_ticks(f);
      int k = 0;
      int cyc = 0;
      int bad = 0;
      logic got_b = 1'b1;
      logic exp_b = 1'b1;
      while (k < total) begin
         if (mid_wr && cyc == 5) begin
            wr_en = 1'b1; wr_data = d2; line_ctl = f2;
         end
         if (mid_wr && cyc == 6) begin
            wr_en = 1'b0;
            chk("R7 hold_empty low after mid-frame write", hold_empty, 1'b0);
            chk("R8 line_idle low mid-frame", line_idle, 1'b0);
         end
         if (tick) begin
            if (tx_out !== frame_bit(f, d, k / 16) || line_idle !== 1'b0) begin
               if (bad == 0) begin got_b = tx_out; exp_b = frame_bit(f, d, k / 16); end
               bad++;
            end
            k++;
         end
         cyc++;
         @(negedge clk);
      end
      n_checks++;
      if (bad != 0) begin
         n_fails++;
         $display("FAIL R2 R3 R4 R5 R6 R9 R10 frame fmt=%02h data=%02h bad=%0d got=%0b exp=%0b",
                  f, d, bad, got_b, exp_b);
      end
   endtask

   task automatic send(input logic [5:0] f, input logic [7:0] d);
      @(negedge clk);
      line_ctl = f; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 hold_empty falls on write", hold_empty, 1'b0);
      chk("R8 line_idle falls on write", line_idle, 1'b0);
      @(negedge clk);
      chk("R7 hold_empty rises at load", hold_empty, 1'b1);
      chk("R9 start bit at load", tx_out, 1'b0);
      check_frame(f, d, 1'b0, 6'd0, 8'd0);
      chk("R8 line_idle after stop", line_idle, 1'b1);
      chk("R1 line high when idle", tx_out, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset tx_out", tx_out, 1'b1);
      chk("R1 reset hold_empty", hold_empty, 1'b1);
      chk("R1 reset line_idle", line_idle, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int f = 0; f < 64; f++) begin
         send(6'(f), 8'h5A);
         send(6'(f), 8'((f * 37 + 11) & 8'hFF));
      end

      // R10 / R7 / R8: second byte written mid-frame under a different format
      @(negedge clk);
      line_ctl = 6'h1F; wr_en = 1'b1; wr_data = 8'hC3;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      chk("R9 start bit first frame", tx_out, 1'b0);
      check_frame(6'h1F, 8'hC3, 1'b1, 6'h00, 8'h96);
      chk("R8 line_idle low while byte waits", line_idle, 1'b0);
      chk("R7 hold_empty low while byte waits", hold_empty, 1'b0);
      @(negedge clk);
      chk("R7 hold_empty rises at second load", hold_empty, 1'b1);
      chk("R9 start bit second frame", tx_out, 1'b0);
      check_frame(6'h00, 8'h96, 1'b0, 6'd0, 8'd0);
      chk("R8 line_idle after second frame", line_idle, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule